// File: doc/BRIEF.md
# Address-Space Identifier Issuer with Background Table Scrub

This block issues address-space identifiers (ASIDs) to newly created processes and reclaims translations that belong to identifiers about to be reused. Identifiers come from an unsigned up-counter that starts at 1. Software raises a request and holds it until a one-cycle grant arrives carrying the new identifier. When the counter has reached its all-ones value, the next request does not get that value. The counter falls back to 1, and a hardware pass over the hashed page table starts. That pass clears the valid bit of every entry tagged with a non-zero identifier. Identifier zero is reserved for shared or kernel mappings, and its entries pass through the sweep untouched. The request that caused the wrap is held and is granted identifier 1 once the sweep has ended.

The sweep works through the table one cluster (a group of ways) per cycle, from index 0 upward. It reads a cluster, scrubs it and writes it back on the following cycle, so reads and write-backs overlap. The table's read port is shared with the translation walker, and the walker always wins. A sweep read is issued only in a cycle where the walker is not requesting. Write-backs use a separate write port that the walker never uses. A busy output covers the whole sweep, and a one-cycle done pulse marks its end.

Top module: `asid_alloc_scrub`

## Requirements
- R1: After reset, `scrub_busy`, `scrub_done`, `alloc_gnt`, `tbl_rd_en` and `tbl_wr_en` are all low, and the first identifier granted is 1.
- R2: When `alloc_req` is high, the block is not busy and no grant was given in the previous cycle, `alloc_gnt` is high for exactly one cycle in the next cycle. `alloc_asid` then holds the previously granted value plus one, or 1 for the first grant after reset or after a wrap.
- R3: A granted identifier is never 0 and never all-ones. With ASID_W = 4, the granted values run 1 to 14.
- R4: A request accepted while the counter holds all-ones produces no grant. Instead it raises `scrub_busy` in the next cycle, and the counter returns to 1.
- R5: A request that arrives or is held while `scrub_busy` is high is granted only after the sweep. With the request held, the grant comes two cycles after the last busy cycle and carries identifier 1.
- R6: A sweep reads every cluster index exactly once, in ascending order starting from 0. Each read at index i is followed in the next cycle by a write-back to index i, so a sweep performs 2^IDX_W writes.
- R7: `tbl_rd_en` is never high in a cycle where `walk_req` is high. The sweep resumes where it left off once the walker releases the port.
- R8: Each way w of a cluster occupies bits [w*ENT_W +: ENT_W], where ENT_W = 1 + ASID_W + TAG_W + PPN_W. Within a way, the ppn sits in the lowest PPN_W bits, the tag above it, the ASID above the tag, and the valid bit at the top bit. A write-back clears the valid bit of every way whose ASID field is non-zero and leaves all its other bits unchanged. Ways whose ASID field is zero are written back bit for bit as read.
- R9: `scrub_done` is a single-cycle pulse in the cycle right after the last busy cycle, and `scrub_busy` is low while it is high. No grant is issued while `scrub_busy` is high.
- R10: With `walk_req` held low, a sweep keeps `scrub_busy` high for exactly 2^IDX_W + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Identifier request, held until granted |
| alloc_gnt | output | 1 | One-cycle grant |
| alloc_asid | output | ASID_W | Identifier valid while `alloc_gnt` is high |
| scrub_busy | output | 1 | Sweep in progress |
| scrub_done | output | 1 | One-cycle pulse after the final write-back |
| walk_req | input | 1 | Translation walker claims the table read port this cycle |
| tbl_rd_en | output | 1 | Sweep read of one cluster |
| tbl_rd_idx | output | IDX_W | Cluster index being read |
| tbl_rd_data | input | WAYS*ENT_W | Cluster contents, one cycle after the read |
| tbl_wr_en | output | 1 | Write-back of a scrubbed cluster |
| tbl_wr_idx | output | IDX_W | Cluster index being written |
| tbl_wr_data | output | WAYS*ENT_W | Scrubbed cluster contents |

## Verification
The checks assume the following about the block's inputs:
- Requesters keep `alloc_req` high until they see a grant and drop it right after.
- The table returns read data exactly one cycle after `tbl_rd_en`, from the addressed cluster.
- `walk_req` may change in any cycle.

The bench drives these inputs accordingly:
- It raises a request only at a falling edge and clears it at the falling edge where the grant is seen.
- It models the table as a one-cycle-latency memory that only the block writes during sweeps.
- It drives `walk_req` a short delay after each rising edge. The value is either held low or drawn at random from a fixed seed, so sweeps are exercised both without interruption and with random gaps.

// File: rtl/asid_scrub_pkg.sv
package asid_scrub_pkg;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_RUN  = 1'b1
   } sweep_state_e;

   function automatic int unsigned entry_bits(input int unsigned asid_w,
                                              input int unsigned tag_w,
                                              input int unsigned ppn_w);
      return 1 + asid_w + tag_w + ppn_w;
   endfunction

endpackage

// File: rtl/asid_issue_ctr.sv
module asid_issue_ctr #(
   parameter int unsigned ASID_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              sweep_busy,
   output logic              gnt,
   output logic [ASID_W-1:0] asid,
   output logic              wrap_start
);
   localparam logic [ASID_W-1:0] TOP   = '1;
   localparam logic [ASID_W-1:0] FIRST = ASID_W'(1);

   logic [ASID_W-1:0] cnt_q;
   logic [ASID_W-1:0] asid_q;
   logic              gnt_q;
   logic              take;

   assign take       = req && !sweep_busy && !gnt_q;
   assign wrap_start = take && (cnt_q == TOP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= FIRST;
         asid_q <= '0;
         gnt_q  <= 1'b0;
      end else begin
         gnt_q <= take && (cnt_q != TOP);
         if (wrap_start) begin
            cnt_q <= FIRST;
         end else if (take) begin
            asid_q <= cnt_q;
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   assign gnt  = gnt_q;
   assign asid = asid_q;
endmodule

// File: rtl/scrub_walk_seq.sv
module scrub_walk_seq
   import asid_scrub_pkg::*;
#(
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             walk_req,
   output logic             rd_en,
   output logic [IDX_W-1:0] rd_idx,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic             busy,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST = '1;

   sweep_state_e     state_q;
   logic [IDX_W-1:0] rd_idx_q;
   logic [IDX_W-1:0] wb_idx_q;
   logic             all_rd_q;
   logic             wb_vld_q;
   logic             done_q;
   logic             rd_fire;

   assign busy    = (state_q == SQ_RUN);
   assign rd_fire = busy && !all_rd_q && !walk_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         rd_idx_q <= '0;
         wb_idx_q <= '0;
         all_rd_q <= 1'b0;
         wb_vld_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         wb_vld_q <= rd_fire;
         wb_idx_q <= rd_idx_q;
         done_q   <= 1'b0;
         if (state_q == SQ_IDLE) begin
            if (start) begin
               state_q  <= SQ_RUN;
               rd_idx_q <= '0;
               all_rd_q <= 1'b0;
            end
         end else begin
            if (rd_fire) begin
               rd_idx_q <= rd_idx_q + 1'b1;
               if (rd_idx_q == LAST) all_rd_q <= 1'b1;
            end
            if (wb_vld_q && (wb_idx_q == LAST)) begin
               state_q <= SQ_IDLE;
               done_q  <= 1'b1;
            end
         end
      end
   end

   assign rd_en  = rd_fire;
   assign rd_idx = rd_idx_q;
   assign wr_en  = wb_vld_q;
   assign wr_idx = wb_idx_q;
   assign done   = done_q;
endmodule

// File: rtl/cluster_scrub.sv
module cluster_scrub
   import asid_scrub_pkg::*;
#(
   parameter int unsigned WAYS   = 4,
   parameter int unsigned ASID_W = 4,
   parameter int unsigned TAG_W  = 6,
   parameter int unsigned PPN_W  = 6,
   localparam int unsigned ENT_W = entry_bits(ASID_W, TAG_W, PPN_W),
   localparam int unsigned CL_W  = WAYS * ENT_W
) (
   input  logic [CL_W-1:0] cl_in,
   output logic [CL_W-1:0] cl_out
);
   localparam int unsigned ASID_LSB = PPN_W + TAG_W;
   localparam int unsigned VLD_BIT  = ENT_W - 1;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [ENT_W-1:0]  ent;
      logic [ASID_W-1:0] ent_asid;
      logic              private_map;

      assign ent         = cl_in[w*ENT_W +: ENT_W];
      assign ent_asid    = ent[ASID_LSB +: ASID_W];
      assign private_map = (ent_asid != '0);

      always_comb begin
         cl_out[w*ENT_W +: ENT_W] = ent;
         if (private_map) cl_out[w*ENT_W + VLD_BIT] = 1'b0;
      end
   end
endmodule

// File: rtl/asid_alloc_scrub.sv
module asid_alloc_scrub
   import asid_scrub_pkg::*;
#(
   parameter int unsigned ASID_W = 4,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned WAYS   = 4,
   parameter int unsigned TAG_W  = 6,
   parameter int unsigned PPN_W  = 6,
   localparam int unsigned ENT_W = entry_bits(ASID_W, TAG_W, PPN_W),
   localparam int unsigned CL_W  = WAYS * ENT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_req,
   output logic              alloc_gnt,
   output logic [ASID_W-1:0] alloc_asid,
   output logic              scrub_busy,
   output logic              scrub_done,
   input  logic              walk_req,
   output logic              tbl_rd_en,
   output logic [IDX_W-1:0]  tbl_rd_idx,
   input  logic [CL_W-1:0]   tbl_rd_data,
   output logic              tbl_wr_en,
   output logic [IDX_W-1:0]  tbl_wr_idx,
   output logic [CL_W-1:0]   tbl_wr_data
);
   if (ASID_W < 2) begin : g_bad_asid
      $error("ASID_W must be at least 2");
   end
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("IDX_W must be in 1..12");
   end
   if (WAYS < 1 || WAYS > 64) begin : g_bad_ways
      $error("WAYS must be in 1..64");
   end

   logic wrap_start;
   logic busy;

   asid_issue_ctr #(.ASID_W(ASID_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (alloc_req),
      .sweep_busy (busy),
      .gnt        (alloc_gnt),
      .asid       (alloc_asid),
      .wrap_start (wrap_start)
   );

   scrub_walk_seq #(.IDX_W(IDX_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (wrap_start),
      .walk_req (walk_req),
      .rd_en    (tbl_rd_en),
      .rd_idx   (tbl_rd_idx),
      .wr_en    (tbl_wr_en),
      .wr_idx   (tbl_wr_idx),
      .busy     (busy),
      .done     (scrub_done)
   );

   cluster_scrub #(
      .WAYS   (WAYS),
      .ASID_W (ASID_W),
      .TAG_W  (TAG_W),
      .PPN_W  (PPN_W)
   ) u_scrub (
      .cl_in  (tbl_rd_data),
      .cl_out (tbl_wr_data)
   );

   assign scrub_busy = busy;
endmodule

// File: rtl/asid_alloc_scrub_chk.sv
module asid_alloc_scrub_chk #(
   parameter int unsigned ASID_W = 4,
   parameter int unsigned IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              alloc_gnt,
   input logic [ASID_W-1:0] alloc_asid,
   input logic              scrub_busy,
   input logic              scrub_done,
   input logic              walk_req,
   input logic              tbl_rd_en,
   input logic [IDX_W-1:0]  tbl_rd_idx,
   input logic              tbl_wr_en,
   input logic [IDX_W-1:0]  tbl_wr_idx
);
   localparam logic [ASID_W-1:0] TOP = '1;

   logic [IDX_W-1:0]  nxt_wr_q;
   logic [ASID_W-1:0] last_q;
   logic [ASID_W-1:0] exp_asid;

   assign exp_asid = (last_q == '0 || last_q == TOP - 1'b1) ? ASID_W'(1) : last_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nxt_wr_q <= '0;
         last_q   <= '0;
      end else begin
         if (scrub_done)     nxt_wr_q <= '0;
         else if (tbl_wr_en) nxt_wr_q <= nxt_wr_q + 1'b1;
         if (alloc_gnt) last_q <= alloc_asid;
      end
   end

   AST_RD_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_rd_en |-> !walk_req);                                          // R7
   AST_RD_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_rd_en |-> scrub_busy);                                         // R6
   AST_WB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_rd_en |=> tbl_wr_en && (tbl_wr_idx == $past(tbl_rd_idx)));     // R6
   AST_WB_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_wr_en |-> (tbl_wr_idx == nxt_wr_q));                           // R6
   AST_NO_GNT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_gnt |-> !scrub_busy);                                        // R9
   AST_GNT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_gnt |=> !alloc_gnt);                                         // R2
   AST_ASID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_gnt |-> (alloc_asid != '0) && (alloc_asid != TOP));          // R3
   AST_ASID_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_gnt |-> (alloc_asid == exp_asid));                           // R2
   AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      scrub_done |-> !scrub_busy && $past(scrub_busy));                  // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      scrub_done |=> !scrub_done);                                       // R9
endmodule

bind asid_alloc_scrub asid_alloc_scrub_chk #(
   .ASID_W (ASID_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .alloc_gnt  (alloc_gnt),
   .alloc_asid (alloc_asid),
   .scrub_busy (scrub_busy),
   .scrub_done (scrub_done),
   .walk_req   (walk_req),
   .tbl_rd_en  (tbl_rd_en),
   .tbl_rd_idx (tbl_rd_idx),
   .tbl_wr_en  (tbl_wr_en),
   .tbl_wr_idx (tbl_wr_idx)
);

// File: tb/sim_asid_alloc_scrub.sv
`timescale 1ns/1ps
module sim_asid_alloc_scrub;
   localparam int ASID_W = 4;
   localparam int IDX_W  = 4;
   localparam int WAYS   = 4;
   localparam int TAG_W  = 6;
   localparam int PPN_W  = 6;
   localparam int ENT_W  = 1 + ASID_W + TAG_W + PPN_W;
   localparam int CL_W   = WAYS * ENT_W;
   localparam int NCL    = 1 << IDX_W;
   localparam int NGRANT = (1 << ASID_W) - 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_req = 1'b0;
   logic walk_req = 1'b0;
   logic alloc_gnt, scrub_busy, scrub_done, tbl_rd_en, tbl_wr_en;
   logic [ASID_W-1:0] alloc_asid;
   logic [IDX_W-1:0]  tbl_rd_idx, tbl_wr_idx;
   logic [CL_W-1:0]   tbl_rd_data, tbl_wr_data;

   logic [CL_W-1:0] mem    [NCL];
   logic [CL_W-1:0] golden [NCL];
   logic            pre_we = 1'b0;
   logic [IDX_W-1:0] pre_idx = '0;
   logic [CL_W-1:0]  pre_data = '0;
   bit   walk_rand = 1'b0;
   bit   done_flag = 1'b0;
   int   n_checks = 0;
   int   n_fails  = 0;

   always #4 clk = ~clk;

   asid_alloc_scrub u0 (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
      .alloc_asid(alloc_asid), .scrub_busy(scrub_busy), .scrub_done(scrub_done),
      .walk_req(walk_req), .tbl_rd_en(tbl_rd_en), .tbl_rd_idx(tbl_rd_idx),
      .tbl_rd_data(tbl_rd_data), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
      .tbl_wr_data(tbl_wr_data)
   );

   // table model: one-cycle read latency, separate write port
   always @(posedge clk) begin
      if (tbl_rd_en) tbl_rd_data <= mem[tbl_rd_idx];
      if (tbl_wr_en)   mem[tbl_wr_idx] <= tbl_wr_data;
      else if (pre_we) mem[pre_idx]    <= pre_data;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected scrub result, from the field layout of R8
   function automatic logic [CL_W-1:0] scrub_exp(input logic [CL_W-1:0] c);
      logic [CL_W-1:0] r = c;
      for (int w = 0; w < WAYS; w++) begin
         if (c[w*ENT_W + PPN_W + TAG_W +: ASID_W] != '0)
            r[w*ENT_W + ENT_W - 1] = 1'b0;
      end
      return r;
   endfunction

   function automatic logic [ENT_W-1:0] rand_entry();
      logic [ENT_W-1:0] e;
      e[ENT_W-1] = 1'($urandom % 2);
      e[PPN_W + TAG_W +: ASID_W] = ($urandom % 3 == 0) ? '0 : ASID_W'($urandom);
      e[PPN_W +: TAG_W] = TAG_W'($urandom);
      e[0 +: PPN_W]     = PPN_W'($urandom);
      return e;
   endfunction

   task automatic preload();
      for (int i = 0; i < NCL; i++) begin
         logic [CL_W-1:0] c;
         for (int w = 0; w < WAYS; w++) c[w*ENT_W +: ENT_W] = rand_entry();
         @(negedge clk);
         pre_we = 1'b1; pre_idx = IDX_W'(i); pre_data = c;
         golden[i] = c;
      end
      @(negedge clk);
      pre_we = 1'b0;
   endtask

   // walker stimulus, changed shortly after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         walk_req = walk_rand ? (($urandom % 100) < 40) : 1'b0;
      end
   end

   // port monitor sampled at falling edges
   bit prev_rd = 1'b0, prev_busy = 1'b0, prev_done = 1'b0;
   logic [IDX_W-1:0] prev_rd_idx = '0;
   int exp_wr = 0, wr_count = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (tbl_rd_en && walk_req) chk(1'b0, "R7 read while walker active", 1, 0);
         if (prev_rd) begin
            chk(tbl_wr_en, "R6 write-back follows read", tbl_wr_en, 1);
            chk(tbl_wr_idx == prev_rd_idx, "R6 write index", tbl_wr_idx, prev_rd_idx);
         end
         if (tbl_wr_en) begin
            chk(int'(tbl_wr_idx) == exp_wr, "R6 ascending order", tbl_wr_idx, exp_wr);
            exp_wr++; wr_count++;
         end
         if (scrub_done) begin
            chk(!scrub_busy && prev_busy, "R9 done after busy", scrub_busy, 0);
            chk(!prev_done, "R9 done single pulse", prev_done, 0);
            chk(wr_count == NCL, "R6 writes per sweep", wr_count, NCL);
            wr_count = 0; exp_wr = 0;
         end
         if (alloc_gnt && scrub_busy) chk(1'b0, "R9 grant while busy", 1, 0);
      end
      prev_rd = tbl_rd_en; prev_rd_idx = tbl_rd_idx;
      prev_busy = scrub_busy; prev_done = scrub_done;
   end

   task automatic alloc_one(output logic [ASID_W-1:0] a, output int lat,
                            output int bcyc, output int dcnt, output int done_at,
                            output bit first_busy);
      @(negedge clk);
      alloc_req = 1'b1;
      lat = 0; bcyc = 0; dcnt = 0; done_at = 0; first_busy = 1'b0;
      forever begin
         @(negedge clk);
         lat++;
         if (lat == 1) first_busy = scrub_busy;
         if (scrub_busy) bcyc++;
         if (scrub_done) begin dcnt++; done_at = lat; end
         if (alloc_gnt || lat > 3000) break;
      end
      a = alloc_asid;
      alloc_req = 1'b0;
   endtask

   task automatic check_table(input string req);
      int bad = 0;
      for (int i = 0; i < NCL; i++) begin
         logic [CL_W-1:0] e = scrub_exp(golden[i]);
         if (mem[i] !== e) begin
            bad++;
            chk(1'b0, req, mem[i], e);
         end
      end
      chk(bad == 0, req, bad, 0);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         chk(1'b0, "watchdog", 0, 1);
         report();
      end
   end

   initial begin
      logic [ASID_W-1:0] a;
      int lat, bcyc, dcnt, done_at;
      bit fb;
      void'($urandom(32'h5EED_A51D));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!scrub_busy, "R1 busy after reset", scrub_busy, 0);
      chk(!scrub_done, "R1 done after reset", scrub_done, 0);
      chk(!alloc_gnt,  "R1 grant after reset", alloc_gnt, 0);
      chk(!tbl_rd_en && !tbl_wr_en, "R1 table idle after reset", {tbl_rd_en, tbl_wr_en}, 0);

      preload();

      // R2/R3 sequential grants with random gaps
      for (int i = 1; i <= NGRANT; i++) begin
         repeat ($urandom % 3) @(negedge clk);
         alloc_one(a, lat, bcyc, dcnt, done_at, fb);
         chk(int'(a) == i, (i == 1) ? "R1 first identifier" : "R2 next identifier", a, i);
         chk(lat == 1, "R2 grant latency", lat, 1);
         chk(a != '0 && a != '1, "R3 identifier range", a, i);
         chk(bcyc == 0, "R4 no sweep before wrap", bcyc, 0);
      end

      // wrap with walker idle: R4, R5, R9, R10, R8
      alloc_one(a, lat, bcyc, dcnt, done_at, fb);
      chk(fb, "R4 busy right after wrap request", fb, 1);
      chk(bcyc == NCL + 1, "R10 sweep length", bcyc, NCL + 1);
      chk(dcnt == 1, "R9 one done pulse", dcnt, 1);
      chk(done_at == NCL + 2, "R9 done timing", done_at, NCL + 2);
      chk(lat == NCL + 3, "R5 grant after sweep", lat, NCL + 3);
      chk(a == ASID_W'(1), "R4 identifier after wrap", a, 1);
      check_table("R8 scrubbed table");

      // second round with a random walker: R7, R2, R8
      walk_rand = 1'b1;
      for (int i = 2; i <= NGRANT; i++) begin
         repeat ($urandom % 4) @(negedge clk);
         alloc_one(a, lat, bcyc, dcnt, done_at, fb);
         chk(int'(a) == i, "R2 identifier after wrap", a, i);
      end
      preload();
      alloc_one(a, lat, bcyc, dcnt, done_at, fb);
      chk(fb, "R4 busy on second wrap", fb, 1);
      chk(bcyc >= NCL + 1, "R7 sweep stretched by walker", bcyc, NCL + 1);
      chk(dcnt == 1 && lat == done_at + 1, "R5 grant after done", lat, done_at + 1);
      chk(a == ASID_W'(1), "R4 identifier after second wrap", a, 1);
      check_table("R8 scrub with walker");
      walk_rand = 1'b0;

      repeat (4) @(negedge clk);
      done_flag = 1'b1;
      report();
   end
endmodule